// File: doc/BRIEF.md
# Scalar Single-Precision Square Root Unit

This unit takes the square root of one IEEE-754 binary32 value held in the low 32 bits of a 128-bit radicand operand. The root goes into the low 32 bits of a 128-bit result. The upper 96 bits of that result come unchanged from a second, merge operand. A 32-bit control/status word comes in with each operation and selects the rounding direction and the denormals-as-zero treatment. The unit returns that word with the invalid, denormal and precision flags ORed in.

The root is built one bit per cycle by a restoring digit recurrence. A denormal mantissa is normalised first. The exponent is made even by shifting the mantissa one place, and the recurrence produces 24 root bits plus a guard bit and a sticky remainder. Special operands (zeros, infinities, NaNs, negative values) skip the recurrence and finish in two cycles. Finite positive operands take 27 cycles. A `start_i` pulse while idle launches an operation. `busy_o` stays high until the one-cycle `done_o` pulse that presents the result and status.

Top module: `sqrt_ss_unit`

## Requirements
- R1: `result_o[127:32]` equals `merge_i[127:32]` captured at start; `radicand_i[127:32]` has no effect on any output.
- R2: An input of +0 (0x00000000) or -0 (0x80000000) returns the same value and raises no flag, whatever the rounding mode or the DAZ and FZ settings.
- R3: +infinity (0x7F800000) returns +infinity with no flag. -infinity, and any negative nonzero value not flushed by DAZ, returns 0xFFC00000 and sets IE (status bit 0).
- R4: An exact root raises no flag: 256.0 gives 16.0 (0x41800000), 529.0 gives 23.0, and 0x466F4840 gives 123.75 (0x42F78000).
- R5: An inexact result sets PE (bit 5) and is rounded by RC (bits 14:13: 00 nearest-even, 01 down, 10 up, 11 toward zero). For example sqrt(528) is 0x41B7D375 under nearest and 0x41B7D376 under up, and 0x3E43FFFF gives 0x3EDFFFFF under down and 0x3EE00000 under up.
- R6: With DAZ (bit 6) clear, a denormal input sets DE (bit 1) and is rooted at full precision: 0x00000001 gives 0x1A3504F3 (0x1A3504F4 under up) and 0x007FFFFF gives 0x1FFFFFFF (0x1FFFFFFE under down), each with PE.
- R7: With DAZ set, a denormal input is treated as a zero of its own sign: 0x80400000 gives 0x80000000, and neither DE nor IE is raised.
- R8: FZ (bit 15) has no effect on the result or on the flags.
- R9: `csr_o` equals the `csr_i` captured at start with the newly raised flags ORed in. All other bits pass through unchanged.
- R10: A quiet NaN (exponent all ones, bit 22 set) is returned unchanged with no flag. A signalling NaN is returned with bit 22 set and IE raised.
- R11: After reset `busy_o` and `done_o` are low. `start_i` while busy is ignored. `done_o` is high for exactly one cycle per operation and never together with `busy_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Launch an operation when idle |
| radicand_i | input | 128 | Operand whose low 32 bits are rooted |
| merge_i | input | 128 | Source of result bits 127:32 |
| csr_i | input | 32 | Control/status word in |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse: result and status valid |
| result_o | output | 128 | Merged result |
| csr_o | output | 32 | Control/status word with flags merged |

## Verification
The hardest cases to reach from the ports are the roots whose guard and sticky bits sit right at a rounding boundary. One example is a mantissa of all ones that carries into the exponent. Another is a value one unit below a perfect square, where up and down rounding differ in the last place. Random operands almost never land there. The stimulus therefore combines chosen near-square and extreme-denormal operands with a sweep over every exponent. Each exponent uses both extreme and scrambled mantissas, and the rounding mode, DAZ and FZ rotate across the sweep. The expected values come from a double-precision root rounded down to single in the bench.

// File: rtl/sqrt_pkg.sv
package sqrt_pkg;
  localparam int EXP_W   = 8;
  localparam int FRAC_W  = 23;
  localparam int WORD_W  = 1 + EXP_W + FRAC_W;
  localparam int MANT_W  = FRAC_W + 1;
  localparam int ROOT_W  = MANT_W + 1;
  localparam int RAD_W   = 2 * ROOT_W;
  localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
  localparam int CSR_W   = 32;
  localparam int VEC_W   = 128;

  localparam int FLG_IE  = 0;
  localparam int FLG_DE  = 1;
  localparam int FLG_PE  = 5;
  localparam int CTL_DAZ = 6;
  localparam int CTL_RC  = 13;

  localparam logic [WORD_W-1:0] DEF_NAN = 32'hFFC0_0000;

  typedef enum logic [1:0] {RC_NEAR = 2'b00, RC_DOWN = 2'b01, RC_UP = 2'b10, RC_ZERO = 2'b11} rc_e;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN} st_e;

  typedef struct packed {
    logic              special;
    logic [WORD_W-1:0] spec_val;
    logic              ie;
    logic              de;
    logic [RAD_W-1:0]  rad;
    logic [EXP_W-1:0]  rexp;
  } prep_t;
endpackage

// File: rtl/sqrt_prep.sv
module sqrt_prep
  import sqrt_pkg::*;
(
  input  logic [WORD_W-1:0] x_i,
  input  logic              daz_i,
  output prep_t             prep_o
);
  logic              sgn, is_nan, is_inf, is_den, is_zero, odd;
  logic [EXP_W-1:0]  ex;
  logic [FRAC_W-1:0] fr;
  logic [4:0]        lead;
  logic [MANT_W-1:0] mant;
  logic signed [10:0] unb, evn, half;

  always_comb begin
    sgn     = x_i[WORD_W-1];
    ex      = x_i[WORD_W-2:FRAC_W];
    fr      = x_i[FRAC_W-1:0];
    is_nan  = (ex == '1) && (fr != '0);
    is_inf  = (ex == '1) && (fr == '0);
    is_den  = (ex == '0) && (fr != '0);
    is_zero = (ex == '0) && ((fr == '0) || daz_i);

    lead = '0;
    for (int i = 0; i < FRAC_W; i++)
      if (fr[i]) lead = 5'(i);

    if (is_den) begin
      mant = MANT_W'({1'b0, fr}) << (5'(FRAC_W) - lead);
      unb  = $signed({6'b0, lead}) - 11'sd149;
    end else begin
      mant = {1'b1, fr};
      unb  = $signed({3'b0, ex}) - 11'(BIAS);
    end
    // even exponent: odd case shifts mantissa one more place
    odd  = unb[0];
    evn  = unb - $signed({10'b0, odd});
    half = (evn >>> 1) + 11'(BIAS);

    prep_o.rad  = odd ? {mant, {(RAD_W-MANT_W){1'b0}}}
                      : {1'b0, mant, {(RAD_W-MANT_W-1){1'b0}}};
    prep_o.rexp = half[EXP_W-1:0];
    prep_o.de   = is_den && !daz_i;
    prep_o.ie   = 1'b0;
    prep_o.special  = 1'b1;
    prep_o.spec_val = x_i;

    if (is_nan) begin
      prep_o.spec_val = x_i | (WORD_W'(1) << (FRAC_W - 1));
      prep_o.ie       = !fr[FRAC_W-1];
    end else if (is_zero) begin
      prep_o.spec_val = {sgn, {(WORD_W-1){1'b0}}};
    end else if (sgn) begin
      prep_o.spec_val = DEF_NAN;
      prep_o.ie       = 1'b1;
    end else if (!is_inf) begin
      prep_o.special  = 1'b0;
    end
  end
endmodule

// File: rtl/sqrt_recur.sv
module sqrt_recur #(
  parameter int ROOT_W = 25
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic                step_i,
  input  logic [2*ROOT_W-1:0] rad_i,
  output logic [ROOT_W-1:0]   root_o,
  output logic                rem_nz_o
);
  localparam int RAD_W = 2 * ROOT_W;
  localparam int REM_W = ROOT_W + 1;
  localparam int CMP_W = ROOT_W + 3;

  logic [RAD_W-1:0]  rad_q;
  logic [REM_W-1:0]  rem_q;
  logic [ROOT_W-1:0] root_q;
  logic [CMP_W-1:0]  rem_sh, trial, rem_sub;
  logic              ge;

  always_comb begin
    rem_sh  = {rem_q, rad_q[RAD_W-1 -: 2]};
    trial   = CMP_W'({root_q, 2'b01});
    ge      = rem_sh >= trial;
    rem_sub = ge ? (rem_sh - trial) : rem_sh;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rad_q  <= '0;
      rem_q  <= '0;
      root_q <= '0;
    end else if (load_i) begin
      rad_q  <= rad_i;
      rem_q  <= '0;
      root_q <= '0;
    end else if (step_i) begin
      rad_q  <= {rad_q[RAD_W-3:0], 2'b00};
      rem_q  <= rem_sub[REM_W-1:0];
      root_q <= {root_q[ROOT_W-2:0], ge};
    end
  end

  assign root_o   = root_q;
  assign rem_nz_o = rem_q != '0;

  // R4
  rem_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    {1'b0, rem_q} <= {1'b0, root_q, 1'b0});
endmodule

// File: rtl/sqrt_round.sv
module sqrt_round
  import sqrt_pkg::*;
(
  input  logic [ROOT_W-1:0] root_i,
  input  logic              sticky_i,
  input  rc_e               rc_i,
  input  logic [EXP_W-1:0]  exp_i,
  output logic [WORD_W-1:0] val_o,
  output logic              inexact_o
);
  logic [MANT_W-1:0] mant;
  logic [MANT_W:0]   sum;
  logic              g, up;
  logic [EXP_W-1:0]  ex;
  logic [FRAC_W-1:0] fr;

  always_comb begin
    mant      = root_i[ROOT_W-1:1];
    g         = root_i[0];
    inexact_o = g | sticky_i;
    unique case (rc_i)
      RC_NEAR: up = g & (sticky_i | mant[0]);
      RC_UP:   up = inexact_o;
      default: up = 1'b0;
    endcase
    sum   = {1'b0, mant} + (MANT_W+1)'(up);
    ex    = exp_i + EXP_W'(sum[MANT_W]);
    fr    = sum[MANT_W] ? '0 : sum[FRAC_W-1:0];
    val_o = {1'b0, ex, fr};
  end
endmodule

// File: rtl/sqrt_ss_unit.sv
module sqrt_ss_unit
  import sqrt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [VEC_W-1:0]  radicand_i,
  input  logic [VEC_W-1:0]  merge_i,
  input  logic [CSR_W-1:0]  csr_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [VEC_W-1:0]  result_o,
  output logic [CSR_W-1:0]  csr_o
);
  localparam int CNT_W = $clog2(ROOT_W);

  st_e                     st_q;
  prep_t                   prep_d, prep_q;
  logic [VEC_W-WORD_W-1:0] hi_q;
  logic [CSR_W-1:0]        csr_q, new_flags;
  logic [CNT_W-1:0]        cnt_q;
  logic [ROOT_W-1:0]       root;
  logic                    rem_nz, inexact, launch;
  logic [WORD_W-1:0]       rnd_val;

  assign launch = (st_q == ST_IDLE) && start_i;
  assign busy_o = st_q != ST_IDLE;

  sqrt_prep u_prep (
    .x_i    (radicand_i[WORD_W-1:0]),
    .daz_i  (csr_i[CTL_DAZ]),
    .prep_o (prep_d)
  );

  sqrt_recur #(.ROOT_W(ROOT_W)) u_recur (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (launch),
    .step_i   (st_q == ST_RUN),
    .rad_i    (prep_d.rad),
    .root_o   (root),
    .rem_nz_o (rem_nz)
  );

  sqrt_round u_round (
    .root_i    (root),
    .sticky_i  (rem_nz),
    .rc_i      (rc_e'(csr_q[CTL_RC+1:CTL_RC])),
    .exp_i     (prep_q.rexp),
    .val_o     (rnd_val),
    .inexact_o (inexact)
  );

  always_comb begin
    new_flags         = '0;
    new_flags[FLG_IE] = prep_q.ie;
    new_flags[FLG_DE] = prep_q.de;
    new_flags[FLG_PE] = !prep_q.special && inexact;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      prep_q   <= '0;
      hi_q     <= '0;
      csr_q    <= '0;
      cnt_q    <= '0;
      done_o   <= 1'b0;
      result_o <= '0;
      csr_o    <= '0;
    end else begin
      done_o <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          prep_q <= prep_d;
          hi_q   <= merge_i[VEC_W-1:WORD_W];
          csr_q  <= csr_i;
          cnt_q  <= '0;
          st_q   <= prep_d.special ? ST_FIN : ST_RUN;
        end
        ST_RUN: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CNT_W'(ROOT_W - 1)) st_q <= ST_FIN;
        end
        ST_FIN: begin
          done_o   <= 1'b1;
          result_o <= {hi_q, prep_q.special ? prep_q.spec_val : rnd_val};
          csr_o    <= csr_q | new_flags;
          st_q     <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R11
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R11
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  // R11
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o && st_q != ST_FIN) |=> busy_o);
  // R5
  hidden_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_FIN && !prep_q.special) |-> root[ROOT_W-1]);
  // R9
  flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> ((csr_o & $past(csr_q)) == $past(csr_q)));
endmodule

// File: tb/sim_sqrt_ss_unit.sv
module sim_sqrt_ss_unit;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [127:0] radicand = '0, merge = '0;
  logic [31:0]  csr = '0;
  logic         busy, done;
  logic [127:0] result;
  logic [31:0]  csr_out;
  int           n_chk = 0, n_fail = 0;
  bit           ended = 0;
  logic [31:0]  seed = 32'h1234_5678;

  always #(CLK_PERIOD/2) clk = ~clk;

  sqrt_ss_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .radicand_i(radicand),
    .merge_i(merge), .csr_i(csr), .busy_o(busy), .done_o(done),
    .result_o(result), .csr_o(csr_out)
  );

  function automatic logic [31:0] rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  // reference: {status, value}
  function automatic logic [63:0] ref_op(input logic [31:0] x, input logic [31:0] c);
    logic s; logic [7:0] e; logic [22:0] f; logic [1:0] rc;
    logic ie, de, pe, up, inx;
    logic [31:0] v; logic [63:0] b; logic [24:0] m2; logic [10:0] dex;
    real rv, rr;
    s = x[31]; e = x[30:23]; f = x[22:0]; rc = c[14:13];
    ie = 0; de = 0; pe = 0; v = x;
    if (e == 8'hFF && f != 0) begin
      v = x | 32'h0040_0000; ie = !f[22];
    end else if (e == 0 && (f == 0 || c[6])) begin
      v = {s, 31'b0};
    end else begin
      if (e == 0) de = 1;
      if (s) begin v = 32'hFFC0_0000; ie = 1; end
      else if (e != 8'hFF) begin
        if (e == 0) rv = real'(f) * (2.0 ** (-149));
        else rv = $bitstoreal({1'b0, 11'(32'(e) + 896), f, 29'b0});
        rr  = $sqrt(rv);
        b   = $realtobits(rr);
        inx = b[28:0] != 0;
        case (rc)
          2'b00: up = b[28] & ((b[27:0] != 0) | b[29]);
          2'b10: up = inx;
          default: up = 0;
        endcase
        m2  = {1'b0, 1'b1, b[51:29]} + 25'(up);
        dex = b[62:52] - 11'd896 + 11'(m2[24]);
        v   = {1'b0, dex[7:0], m2[24] ? 23'b0 : m2[22:0]};
        pe  = inx;
      end
    end
    return {c | (32'(ie) << 0) | (32'(de) << 1) | (32'(pe) << 5), v};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [127:0] rad, input logic [127:0] mg, input logic [31:0] c, input string tag);
    logic [63:0] e;
    int n;
    @(negedge clk);
    radicand = rad; merge = mg; csr = c; start = 1'b1;
    @(negedge clk);
    start = 1'b0; radicand = {rnd(), rnd(), rnd(), rnd()};
    n = 0;
    while (!done && n < 100) begin @(negedge clk); n++; end
    e = ref_op(rad[31:0], c);
    check(result == {mg[127:32], e[31:0]}, tag, result, {mg[127:32], e[31:0]});
    check(csr_out == e[63:32], tag, 128'(csr_out), 128'(e[63:32]));
  endtask

  task automatic op(input logic [31:0] x, input logic [1:0] rc, input bit daz, input bit fz, input string tag);
    logic [31:0] c;
    c = (32'(rc) << 13) | (32'(daz) << 6) | (32'(fz) << 15);
    run_op({rnd(), rnd(), rnd(), x}, {rnd(), rnd(), rnd(), rnd()}, c, tag);
  endtask

  function automatic logic [31:0] mk(input logic [31:0] x, input logic [1:0] rc);
    mk = ref_op(x, 32'(rc) << 13);
    return mk;
  endfunction

  initial begin
    #(CLK_PERIOD * 190000);
    if (!ended) begin
      ended = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [63:0] ea;
    repeat (3) @(negedge clk);
    // R11 reset state
    check(!busy && !done, "R11", {126'b0, busy, done}, 128'b0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 signed zeros in all modes
    for (int rc = 0; rc < 4; rc++) begin
      op(32'h0000_0000, 2'(rc), rc[0], rc[1], "R2");
      op(32'h8000_0000, 2'(rc), rc[1], rc[0], "R2");
    end
    // R3 infinities and negatives
    op(32'h7F80_0000, 2'b00, 0, 0, "R3");
    op(32'hFF80_0000, 2'b11, 0, 1, "R3");
    op(32'hC380_8000, 2'b00, 0, 0, "R3");
    op(32'h8000_0005, 2'b10, 0, 0, "R3");
    check(mk(32'hFF80_0000, 0) == 32'hFFC0_0000, "R3", 128'(mk(32'hFF80_0000, 0)), 128'hFFC0_0000);
    // R4 exact roots
    op(32'h4380_0000, 2'b11, 0, 0, "R4");
    op(32'h4404_4000, 2'b00, 0, 0, "R4");
    op(32'h466F_4840, 2'b00, 0, 0, "R4");
    check(mk(32'h4380_0000, 0) == 32'h4180_0000, "R4", 128'(mk(32'h4380_0000, 0)), 128'h4180_0000);
    // R5 directed rounding
    op(32'h4404_0000, 2'b00, 0, 0, "R5");
    op(32'h4404_0000, 2'b10, 0, 0, "R5");
    op(32'h3E43_FFFF, 2'b01, 0, 0, "R5");
    op(32'h3E43_FFFF, 2'b10, 0, 0, "R5");
    op(32'h7F7F_FFFF, 2'b10, 0, 0, "R5");
    check(mk(32'h4404_0000, 2) == 32'h41B7_D376, "R5", 128'(mk(32'h4404_0000, 2)), 128'h41B7_D376);
    // R6 denormals with DAZ clear
    op(32'h0000_0001, 2'b00, 0, 0, "R6");
    op(32'h0000_0001, 2'b10, 0, 1, "R6");
    op(32'h007F_FFFF, 2'b00, 0, 0, "R6");
    op(32'h007F_FFFF, 2'b01, 0, 0, "R6");
    check(mk(32'h0000_0001, 0) == 32'h1A35_04F3, "R6", 128'(mk(32'h0000_0001, 0)), 128'h1A35_04F3);
    // R7 DAZ
    op(32'h8040_0000, 2'b00, 1, 1, "R7");
    op(32'h0001_2345, 2'b10, 1, 0, "R7");
    // R8 FZ has no effect
    op(32'h0000_0001, 2'b00, 0, 1, "R8");
    op(32'h4404_0000, 2'b11, 0, 1, "R8");
    // R9 status passthrough with preset bits
    run_op({96'h0, 32'h4404_0000}, '1, 32'hA5A5_1F9C, "R9");
    run_op({96'h0, 32'h4380_0000}, '0, 32'hFFFF_FFFF, "R9");
    // R10 NaNs
    op(32'h7FC1_2345, 2'b00, 0, 0, "R10");
    op(32'h7F81_2345, 2'b00, 0, 0, "R10");
    op(32'hFF80_0001, 2'b10, 1, 1, "R10");
    // R1 merge and ignored radicand upper bits
    run_op({96'hDEAD_BEEF_0123_4567_89AB_CDEF, 32'h4404_4000}, {96'h1111_2222_3333_4444_5555_6666, 32'h0}, 0, "R1");

    // R11 start ignored while busy; done lasts one cycle
    @(negedge clk);
    radicand = {96'h0, 32'h4404_0000}; merge = '0; csr = 32'h0000_4000; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy, "R11", 128'(busy), 128'd1);
    repeat (3) @(negedge clk);
    radicand = {96'h0, 32'h7F80_0000}; merge = '1; csr = 0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    ea = ref_op(32'h4404_0000, 32'h0000_4000);
    check(result == {96'h0, ea[31:0]}, "R11", result, {96'h0, ea[31:0]});
    @(negedge clk);
    check(!done && !busy, "R11", {126'b0, busy, done}, 128'b0);

    // R5 exponent sweep with rotating modes
    for (int e = 0; e < 256; e++) begin
      for (int k = 0; k < 2; k++) begin
        logic [22:0] fr;
        fr = (k == 0) ? ((e % 3 == 0) ? 23'h7F_FFFF : 23'h00_0001) : rnd()[22:0];
        op({(e % 11 == 0), 8'(e), fr}, 2'(e + k), e[3], e[4], "R5");
      end
    end
    // R5 random operands
    for (int i = 0; i < 600; i++) begin
      logic [31:0] r;
      r = rnd();
      op(r, r[1:0], r[2], r[3], "R5");
    end

    if (!ended) begin
      ended = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule